// File: doc/BRIEF.md
# Variable-Width Link Packet Serializer

This block carries packets made of 32-bit words across a narrow point-to-point link whose lane count is chosen by configuration. On the sending side each word is cut into bit times as wide as the link, lowest bits first. A flag that marks control words travels with every bit time, and a last-flag marks the final bit time of the packet. The receiving side collects the bit times back into 32-bit words and reports a packet that ends in the middle of a word. The sender can place an extended-address control word ahead of the first word, and it zero-pads the unused bytes of the final word.

One core clock cycle carries one bit time. When the link moves data on both edges, the core clock runs at twice the link clock. The transmit bus and the receive bus are separate ports, so the two halves can sit at opposite ends of a link or be looped back. The lane width is held in a register. That register takes a new width code only while both halves are between packets.

Sender states: `TX_IDLE` waits for a start-of-packet word. `TX_IDLE -> TX_EXT` when the extended address is requested, otherwise `TX_IDLE -> TX_SEND`. `TX_EXT -> TX_SEND` after the last bit time of the extended word. In `TX_SEND`, after the last bit time of a word: `TX_SEND -> TX_IDLE` if the word ended the packet, `TX_SEND -> TX_SEND` if the next word is already offered, and `TX_SEND -> TX_FETCH` otherwise. `TX_FETCH -> TX_SEND` when a word arrives.

Receiver states: `RX_IDLE -> RX_BUSY` on a bit time that is not the last one of the packet. `RX_BUSY -> RX_IDLE` on the bit time that carries the last-flag.

Top module: `lnk_serdes`

## Requirements
- R1: After reset, in_ready is 1 and tx_valid, tx_last, out_valid and out_err are all 0.
- R2: With width W, every 32-bit word occupies exactly 32/W bit times on the transmit bus, and tx_valid is high for each of them.
- R3: In bit time k of a word, lane i carries word bit k*W+i. Lanes at index W and above are 0.
- R4: cfg_width is a code c, and W = 2^c for c = 1..5 (2, 4, 8, 16, 32 lanes). Codes 0, 6 and 7 are ignored and the previous width stays in force.
- R5: The first word of a packet is always sent with tx_ctl=1. Every later word is sent with the in_ctl value it was given.
- R6: If in_ext64 is 1 with the start word, the control word {EXT_CMD (8'h3F), in_addr_hi[23:0]} is sent with tx_ctl=1 before the start word.
- R7: On the word that carries in_eop, in_bytes = 1, 2 or 3 keeps only that many low bytes and sends the rest as zero. in_bytes = 0 keeps all four bytes.
- R8: tx_last is 1 only on the final bit time of the final word of a packet.
- R9: A word offered without in_sop while the sender is idle is consumed (in_ready=1) and dropped, so nothing appears on the link.
- R10: The receiver asserts out_valid one cycle after the final bit time of each word. It presents the rebuilt word, the control flag of the word's first bit time, and out_last equal to rx_last.
- R11: If rx_last arrives on a bit time that is not the final one of a word, out_err pulses for one cycle with no out_valid. The receiver then starts the next word at bit 0.
- R12: A width change offered during a packet has no effect until the packet is over. It then applies to the following packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one bit time per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | 3 | Lane width code, W = 2^code |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word taken this cycle |
| in_data | input | 32 | Input word |
| in_sop | input | 1 | Word starts a packet |
| in_eop | input | 1 | Word ends a packet |
| in_ctl | input | 1 | Word is a control word (non-start words) |
| in_ext64 | input | 1 | Prepend the extended-address word (start word only) |
| in_addr_hi | input | 24 | Upper address bits for the extended word |
| in_bytes | input | 2 | Valid bytes in the final word, 0 means 4 |
| tx_lanes | output | 32 | Transmit lanes |
| tx_valid | output | 1 | Bit time present |
| tx_ctl | output | 1 | Bit time belongs to a control word |
| tx_last | output | 1 | Final bit time of the packet |
| rx_lanes | input | 32 | Receive lanes |
| rx_valid | input | 1 | Received bit time present |
| rx_ctl | input | 1 | Received control flag |
| rx_last | input | 1 | Received last-flag |
| out_valid | output | 1 | Rebuilt word valid |
| out_data | output | 32 | Rebuilt word |
| out_ctl | output | 1 | Rebuilt word is control |
| out_last | output | 1 | Rebuilt word ends the packet |
| out_err | output | 1 | Packet ended partway through a word |

## Verification
The bench rebuilds words from the lanes using its own width and compares them with words it predicts. A swapped lane order or a wrong beat count per width therefore shows up as corrupted data or as an extra or missing word. Directed cases cover:
- every legal width and the illegal codes, where a design that accepted code 0 or 6 would change the beat count;
- a width change in the middle of a packet, which a design that did not freeze the width would apply to the remaining words;
- single-word packets with and without the extended word, where a lost held word or a misplaced last-flag shows;
- each padding byte count, where a wrong mask leaks stale bytes;
- a truncated word on the receive side, where a receiver that did not restart would shift the next word.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
    localparam int WC_W = 3;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_EXT,
        TX_SEND,
        TX_FETCH
    } tx_state_t;

    typedef enum logic {
        RX_IDLE,
        RX_BUSY
    } rx_state_t;

    function automatic logic wcode_ok(input logic [WC_W-1:0] c);
        return (c >= WC_W'(1)) && (c <= WC_W'(5));
    endfunction
endpackage

// File: rtl/lnk_width_reg.sv
module lnk_width_reg
    import lnk_pkg::*;
#(
    parameter logic [WC_W-1:0] RESET_WCODE = 3'd3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [WC_W-1:0] cfg_width,
    input  logic            tx_idle,
    input  logic            rx_idle,
    output logic [WC_W-1:0] wcode
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            wcode <= RESET_WCODE;
        else if (tx_idle && rx_idle && wcode_ok(cfg_width))
            wcode <= cfg_width;
    end
endmodule

// File: rtl/lnk_tx.sv
module lnk_tx
    import lnk_pkg::*;
#(
    parameter int         WORD_W  = 32,
    parameter logic [7:0] EXT_CMD = 8'h3F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WC_W-1:0]   wcode,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_ctl,
    input  logic              in_ext64,
    input  logic [WORD_W-9:0] in_addr_hi,
    input  logic [1:0]        in_bytes,
    output logic [WORD_W-1:0] tx_lanes,
    output logic              tx_valid,
    output logic              tx_ctl,
    output logic              tx_last,
    output logic              tx_idle
);
    localparam int BEAT_W = $clog2(WORD_W);

    tx_state_t         state_q, state_d;
    logic [WORD_W-1:0] shreg_q, hold_q, word_pad, lane_mask;
    logic              hold_last_q, cur_ctl_q, cur_last_q;
    logic [BEAT_W-1:0] beat_q, beat_max;
    logic [BEAT_W:0]   width_v;
    logic              last_beat, accept;

    assign width_v   = (BEAT_W+1)'(1) << wcode;
    assign beat_max  = BEAT_W'((WORD_W >> wcode) - 1);
    assign last_beat = (beat_q == beat_max);
    assign accept    = in_valid && in_ready;

    for (genvar i = 0; i < WORD_W; i++) begin : g_mask
        assign lane_mask[i] = (i < int'(width_v));
    end

    always_comb begin
        word_pad = in_data;
        if (in_eop) begin
            unique case (in_bytes)
                2'd1:    word_pad = in_data & WORD_W'(32'h0000_00FF);
                2'd2:    word_pad = in_data & WORD_W'(32'h0000_FFFF);
                2'd3:    word_pad = in_data & WORD_W'(32'h00FF_FFFF);
                default: word_pad = in_data;
            endcase
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (in_valid && in_sop) state_d = in_ext64 ? TX_EXT : TX_SEND;
            TX_EXT:   if (last_beat) state_d = TX_SEND;
            TX_SEND:  if (last_beat) state_d = cur_last_q ? TX_IDLE : (in_valid ? TX_SEND : TX_FETCH);
            TX_FETCH: if (in_valid) state_d = TX_SEND;
            default:  state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q     <= '0;
            hold_q      <= '0;
            hold_last_q <= 1'b0;
            cur_ctl_q   <= 1'b0;
            cur_last_q  <= 1'b0;
            beat_q      <= '0;
        end else begin
            if ((state_q == TX_EXT) || (state_q == TX_SEND))
                beat_q <= last_beat ? '0 : beat_q + 1'b1;
            else
                beat_q <= '0;
            unique case (state_q)
                TX_IDLE: if (in_valid && in_sop) begin
                    cur_ctl_q <= 1'b1;
                    if (in_ext64) begin
                        shreg_q     <= {EXT_CMD, in_addr_hi};
                        hold_q      <= word_pad;
                        hold_last_q <= in_eop;
                        cur_last_q  <= 1'b0;
                    end else begin
                        shreg_q    <= word_pad;
                        cur_last_q <= in_eop;
                    end
                end
                TX_EXT: if (last_beat) begin
                    shreg_q    <= hold_q;
                    cur_ctl_q  <= 1'b1;
                    cur_last_q <= hold_last_q;
                end else begin
                    shreg_q <= shreg_q >> width_v;
                end
                TX_SEND, TX_FETCH: if (accept) begin
                    shreg_q    <= word_pad;
                    cur_ctl_q  <= in_ctl;
                    cur_last_q <= in_eop;
                end else if (state_q == TX_SEND && !last_beat) begin
                    shreg_q <= shreg_q >> width_v;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        in_ready = 1'b0;
        tx_valid = 1'b0;
        tx_last  = 1'b0;
        unique case (state_q)
            TX_IDLE:  in_ready = 1'b1;
            TX_EXT:   tx_valid = 1'b1;
            TX_SEND: begin
                tx_valid = 1'b1;
                in_ready = last_beat && !cur_last_q;
                tx_last  = last_beat && cur_last_q;
            end
            TX_FETCH: in_ready = 1'b1;
            default: ;
        endcase
        tx_lanes = tx_valid ? (shreg_q & lane_mask) : '0;
        tx_ctl   = tx_valid && cur_ctl_q;
        tx_idle  = (state_q == TX_IDLE);
    end
endmodule

// File: rtl/lnk_rx.sv
module lnk_rx
    import lnk_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WC_W-1:0]   wcode,
    input  logic [WORD_W-1:0] rx_lanes,
    input  logic              rx_valid,
    input  logic              rx_ctl,
    input  logic              rx_last,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_ctl,
    output logic              out_last,
    output logic              out_err,
    output logic              rx_idle
);
    localparam int BEAT_W = $clog2(WORD_W);

    rx_state_t         state_q, state_d;
    logic [BEAT_W-1:0] beat_q, beat_max, shamt;
    logic [WORD_W-1:0] acc_q, word_now, lane_mask;
    logic              ctl_q, ctl_now, last_beat;

    assign beat_max  = BEAT_W'((WORD_W >> wcode) - 1);
    assign last_beat = (beat_q == beat_max);
    assign shamt     = beat_q << wcode;
    assign lane_mask = {WORD_W{1'b1}} >> (WORD_W - (1 << wcode));
    assign word_now  = acc_q | ((rx_lanes & lane_mask) << shamt);
    assign ctl_now   = (beat_q == '0) ? rx_ctl : ctl_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: if (rx_valid && !rx_last) state_d = RX_BUSY;
            RX_BUSY: if (rx_valid && rx_last)  state_d = RX_IDLE;
            default: state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
            acc_q  <= '0;
            ctl_q  <= 1'b0;
        end else if (rx_valid) begin
            if (last_beat || rx_last) begin
                beat_q <= '0;
                acc_q  <= '0;
            end else begin
                beat_q <= beat_q + 1'b1;
                acc_q  <= word_now;
                ctl_q  <= ctl_now;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_ctl   <= 1'b0;
            out_last  <= 1'b0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= rx_valid && last_beat;
            out_err   <= rx_valid && rx_last && !last_beat;
            if (rx_valid && last_beat) begin
                out_data <= word_now;
                out_ctl  <= ctl_now;
                out_last <= rx_last;
            end
        end
    end

    assign rx_idle = (state_q == RX_IDLE);
endmodule

// File: rtl/lnk_serdes.sv
module lnk_serdes
    import lnk_pkg::*;
#(
    parameter int              WORD_W      = 32,
    parameter logic [7:0]      EXT_CMD     = 8'h3F,
    parameter logic [WC_W-1:0] RESET_WCODE = 3'd3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WC_W-1:0]   cfg_width,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_ctl,
    input  logic              in_ext64,
    input  logic [WORD_W-9:0] in_addr_hi,
    input  logic [1:0]        in_bytes,
    output logic [WORD_W-1:0] tx_lanes,
    output logic              tx_valid,
    output logic              tx_ctl,
    output logic              tx_last,
    input  logic [WORD_W-1:0] rx_lanes,
    input  logic              rx_valid,
    input  logic              rx_ctl,
    input  logic              rx_last,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_ctl,
    output logic              out_last,
    output logic              out_err
);
    logic [WC_W-1:0] wcode_q;
    logic            tx_idle, rx_idle;

    lnk_width_reg #(.RESET_WCODE(RESET_WCODE)) u_width (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width),
        .tx_idle(tx_idle), .rx_idle(rx_idle), .wcode(wcode_q)
    );

    lnk_tx #(.WORD_W(WORD_W), .EXT_CMD(EXT_CMD)) u_tx (
        .clk(clk), .rst_n(rst_n), .wcode(wcode_q),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .in_ctl(in_ctl),
        .in_ext64(in_ext64), .in_addr_hi(in_addr_hi), .in_bytes(in_bytes),
        .tx_lanes(tx_lanes), .tx_valid(tx_valid), .tx_ctl(tx_ctl),
        .tx_last(tx_last), .tx_idle(tx_idle)
    );

    lnk_rx #(.WORD_W(WORD_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .wcode(wcode_q),
        .rx_lanes(rx_lanes), .rx_valid(rx_valid), .rx_ctl(rx_ctl),
        .rx_last(rx_last), .out_valid(out_valid), .out_data(out_data),
        .out_ctl(out_ctl), .out_last(out_last), .out_err(out_err),
        .rx_idle(rx_idle)
    );
endmodule

// File: rtl/lnk_serdes_chk.sv
module lnk_serdes_chk
    import lnk_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WC_W-1:0]   wcode,
    input logic [WORD_W-1:0] tx_lanes,
    input logic              tx_valid,
    input logic              tx_last,
    input logic              rx_valid,
    input logic              rx_last,
    input logic              out_valid,
    input logic              out_err
);
    logic [WORD_W-1:0] upper;
    assign upper = ~({WORD_W{1'b1}} >> (WORD_W - (1 << wcode)));

    p_last_in_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);
    p_upper_lanes_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> ((tx_lanes & upper) == '0));
    p_width_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wcode_ok(wcode));
    p_width_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && $past(tx_valid)) |-> $stable(wcode));
    p_word_after_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(rx_valid));
    p_err_after_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> $past(rx_valid && rx_last));
    p_err_no_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_err && out_valid));
endmodule

bind lnk_serdes lnk_serdes_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wcode(wcode_q),
    .tx_lanes(tx_lanes), .tx_valid(tx_valid), .tx_last(tx_last),
    .rx_valid(rx_valid), .rx_last(rx_last),
    .out_valid(out_valid), .out_err(out_err)
);

// File: tb/lnk_serdes_test.sv
module lnk_serdes_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_width = 3'd3;
    logic        in_valid = 0, in_sop = 0, in_eop = 0, in_ctl = 0, in_ext64 = 0;
    logic [31:0] in_data = 0;
    logic [23:0] in_addr_hi = 0;
    logic [1:0]  in_bytes = 0;
    logic        in_ready;
    logic [31:0] tx_lanes, rx_lanes, out_data;
    logic        tx_valid, tx_ctl, tx_last, rx_valid, rx_ctl, rx_last;
    logic        out_valid, out_ctl, out_last, out_err;
    logic        ovr = 0, b_valid = 0, b_ctl = 0, b_last = 0;
    logic [31:0] b_lanes = 0;

    assign rx_lanes = ovr ? b_lanes : tx_lanes;
    assign rx_valid = ovr ? b_valid : tx_valid;
    assign rx_ctl   = ovr ? b_ctl   : tx_ctl;
    assign rx_last  = ovr ? b_last  : tx_last;

    always #4 clk = ~clk;

    lnk_serdes uut (.*);

    int checks = 0, failures = 0, cyc = 0, bw = 8, beats_seen = 0, errs_seen = 0;
    bit done = 0;
    logic [33:0] exp_q[$], lnk_q[$], rx_q[$];
    int lnk_cyc_q[$], rx_cyc_q[$];
    int mbeat = 0;
    logic [31:0] macc;
    logic mctl;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) cyc++;

    always @(negedge clk) if (rst_n) begin
        if (tx_valid) begin
            beats_seen++;
            chk((tx_lanes >> bw) == 0 || bw == 32, "R3", "upper lanes", tx_lanes, 0);
            if (mbeat == 0) begin macc = 0; mctl = tx_ctl; end
            for (int i = 0; i < bw; i++) macc[mbeat*bw+i] = tx_lanes[i];
            if (mbeat == 32/bw - 1) begin
                lnk_q.push_back({tx_last, mctl, macc});
                lnk_cyc_q.push_back(cyc);
                mbeat = 0;
            end else begin
                if (tx_last) chk(0, "R8", "last flag mid-word", 1, 0);
                mbeat++;
            end
        end
        if (out_valid) begin
            rx_q.push_back({out_last, out_ctl, out_data});
            rx_cyc_q.push_back(cyc);
        end
        if (out_err) errs_seen++;
    end

    function automatic logic [31:0] pad(input logic [31:0] d, input logic [1:0] b);
        case (b)
            2'd1: return d & 32'hFF;
            2'd2: return d & 32'hFFFF;
            2'd3: return d & 32'hFF_FFFF;
            default: return d;
        endcase
    endfunction

    task automatic drive_word(input logic [31:0] d, input bit sop, input bit eop,
                              input bit ctl, input bit ext, input logic [23:0] ahi,
                              input logic [1:0] by);
        bit rdy;
        in_valid = 1; in_data = d; in_sop = sop; in_eop = eop;
        in_ctl = ctl; in_ext64 = ext; in_addr_hi = ahi; in_bytes = by;
        do begin
            #1 rdy = in_ready;
            @(posedge clk);
            @(negedge clk);
        end while (!rdy);
        in_valid = 0; in_sop = 0; in_eop = 0;
    endtask

    task automatic set_width(input logic [2:0] c);
        @(negedge clk);
        cfg_width = c;
        repeat (2) @(negedge clk);
        if (c >= 1 && c <= 5) bw = 1 << c;
    endtask

    // words: n words, ctl bits per word, extended flag, pad bytes; mid_code applied after word 0
    task automatic send_pkt(input int n, input logic [31:0] w[8], input logic [7:0] ctls,
                            input bit ext, input logic [23:0] ahi, input logic [1:0] by,
                            input string tag, input int mid_code, input bit gaps);
        int nb;
        nb = 32 / bw;
        exp_q.delete(); lnk_q.delete(); rx_q.delete(); lnk_cyc_q.delete(); rx_cyc_q.delete();
        beats_seen = 0;
        if (ext) exp_q.push_back({1'b0, 1'b1, 8'h3F, ahi});
        for (int i = 0; i < n; i++)
            exp_q.push_back({i == n-1, (i == 0) ? 1'b1 : ctls[i],
                             (i == n-1) ? pad(w[i], by) : w[i]});
        for (int i = 0; i < n; i++) begin
            drive_word(w[i], i == 0, i == n-1, ctls[i], ext, ahi, by);
            if (i == 0 && mid_code >= 0) cfg_width = 3'(mid_code);
            if (gaps) repeat ($urandom_range(0, 2)) @(negedge clk);
        end
        repeat (40) @(negedge clk);
        chk(beats_seen == exp_q.size()*nb, "R2", "bit times in packet", beats_seen, exp_q.size()*nb);
        chk(lnk_q.size() == exp_q.size(), tag, "link word count", lnk_q.size(), exp_q.size());
        chk(rx_q.size() == exp_q.size(), "R10", "rebuilt word count", rx_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size(); i++) begin
            if (i < lnk_q.size())
                chk(lnk_q[i] == exp_q[i], tag, "link word", lnk_q[i], exp_q[i]);
            if (i < rx_q.size()) begin
                chk(rx_q[i] == exp_q[i], "R10", "rebuilt word", rx_q[i], exp_q[i]);
                if (i < lnk_q.size())
                    chk(rx_cyc_q[i] == lnk_cyc_q[i] + 1, "R10", "word latency",
                        rx_cyc_q[i] - lnk_cyc_q[i], 1);
            end
        end
    endtask

    task automatic rx_beat(input logic [31:0] l, input bit c, input bit last);
        b_lanes = l; b_ctl = c; b_last = last; b_valid = 1;
        @(negedge clk);
        b_valid = 0; b_last = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "WATCHDOG", "run timed out", cyc, 150000);
        finish_run();
    end

    initial begin
        logic [31:0] w[8];
        void'($urandom(32'd5751));
        repeat (3) @(negedge clk);
        chk(in_ready == 1 && tx_valid == 0 && tx_last == 0, "R1", "tx reset state",
            {in_ready, tx_valid, tx_last}, 3'b100);
        chk(out_valid == 0 && out_err == 0, "R1", "rx reset state", {out_valid, out_err}, 0);
        rst_n = 1;
        @(negedge clk);

        // every legal width
        for (int c = 1; c <= 5; c++) begin
            set_width(3'(c));
            w = '{32'h8765_4321, 32'hDEAD_BEEF, 32'h0F1E_2D3C, 0, 0, 0, 0, 0};
            send_pkt(3, w, 8'b0000_0100, 0, 0, 0, "R3", -1, 0);
        end
        // data words flagged control or not, start forced control
        set_width(3'd2);
        w = '{32'h1111_2222, 32'h3333_4444, 32'h5555_6666, 32'h7777_8888, 0, 0, 0, 0};
        send_pkt(4, w, 8'b0000_1010, 0, 0, 0, "R5", -1, 0);
        // extended address word, also with a single-word packet
        send_pkt(2, w, 8'b0, 1, 24'hABCDEF, 0, "R6", -1, 0);
        set_width(3'd5);
        send_pkt(1, w, 8'b0, 1, 24'h123456, 0, "R6", -1, 0);
        // padding
        set_width(3'd1);
        for (int b = 1; b <= 3; b++) begin
            w = '{32'hCAFE_F00D, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0};
            send_pkt(2, w, 8'b0, 0, 0, 2'(b), "R7", -1, 0);
        end
        // single word packet: last flag on its final bit time
        send_pkt(1, w, 8'b0, 0, 0, 0, "R8", -1, 0);
        // illegal codes are ignored
        set_width(3'd3);
        set_width(3'd0);
        set_width(3'd6);
        set_width(3'd7);
        w = '{32'h0123_4567, 32'h89AB_CDEF, 0, 0, 0, 0, 0, 0};
        send_pkt(2, w, 8'b0, 0, 0, 0, "R4", -1, 0);
        // word without start while idle is dropped
        lnk_q.delete(); rx_q.delete(); beats_seen = 0;
        drive_word(32'h5A5A_5A5A, 0, 1, 0, 0, 0, 0);
        repeat (20) @(negedge clk);
        chk(beats_seen == 0 && rx_q.size() == 0, "R9", "dropped word produced output",
            beats_seen, 0);
        // width change mid-packet
        set_width(3'd3);
        w = '{32'h1020_3040, 32'h5060_7080, 32'h90A0_B0C0, 32'hD0E0_F001, 0, 0, 0, 0};
        send_pkt(4, w, 8'b0, 0, 0, 0, "R12", 1, 0);
        bw = 2;
        w = '{32'hA1B2_C3D4, 32'hE5F6_0718, 0, 0, 0, 0, 0, 0};
        send_pkt(2, w, 8'b0, 0, 0, 0, "R12", -1, 0);
        // truncated word at the receiver (width 8, four bit times per word)
        set_width(3'd3);
        rx_q.delete(); errs_seen = 0;
        ovr = 1;
        rx_beat(32'hAA, 1, 0);
        rx_beat(32'hBB, 1, 0);
        rx_beat(32'hCC, 1, 1);
        @(negedge clk);
        chk(errs_seen == 1 && rx_q.size() == 0, "R11", "error pulse on short word",
            {errs_seen[3:0], rx_q.size()}, 64'h10);
        rx_beat(32'h11, 1, 0);
        rx_beat(32'h22, 1, 0);
        rx_beat(32'h33, 1, 0);
        rx_beat(32'h44, 1, 1);
        @(negedge clk);
        chk(rx_q.size() == 1, "R11", "word after error count", rx_q.size(), 1);
        if (rx_q.size() == 1)
            chk(rx_q[0] == {2'b11, 32'h4433_2211}, "R11", "restart at bit 0", rx_q[0],
                {2'b11, 32'h4433_2211});
        chk(errs_seen == 1, "R11", "no extra error", errs_seen, 1);
        ovr = 0;
        // random traffic
        for (int p = 0; p < 40; p++) begin
            int n;
            set_width(3'($urandom_range(1, 5)));
            n = $urandom_range(1, 6);
            for (int i = 0; i < 8; i++) w[i] = $urandom;
            send_pkt(n, w, 8'($urandom), 1'($urandom), 24'($urandom), 2'($urandom),
                     "R3", -1, 1);
        end
        finish_run();
    end
endmodule